// File: doc/BRIEF.md
# Trip-Threshold Programming Sequencer

This block sits behind the serial command decoder of a supervisor-with-memory device. It watches a stream of decoded commands (opcode, address, data) together with the chip-select line, the write-protect pin level and a flag saying that write-protect is being driven at the high programming voltage. From these it picks out the calibration sequence that adjusts the supply trip threshold. When it finds that sequence, it raises a one-cycle request either to program the threshold to the present supply level or to return it to its native low level.

The calibration sequence is a write-enable command followed by a write of 00h to one of two special addresses, with write-protect held at the high voltage during the write. The programming request fires when chip-select rises after that write. The operation ends when the write-protect pin falls. Every enabled write, calibration or not, also leaves the block as an ordinary array write of the same address and data. A write that does not meet the calibration conditions is only an ordinary array write.

Commands enter on a valid/ready port. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. Array writes leave on a valid/ready port. `wr_valid` stays high, with address and data unchanged, until `wr_ready` is seen high. While an array write is waiting, or a calibration is in progress, `cmd_ready` is held low. Upstream must then keep its command in place.

Top module: `trip_prog_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `wel`, `wr_valid`, `trip_set`, `trip_reset` and `trip_done` are all 0.
- R2: An accepted write-enable command (opcode 06h) sets `wel` to 1 from the next cycle.
- R3: An accepted write command (opcode 02h) while `wel` is 1 produces exactly one array write carrying the command's address and data, and clears `wel`. A write command while `wel` is 0 produces no array write.
- R4: An enabled write of data 00h to address 01h with `wp_hv` high, followed by a rise of `cs_n`, produces `trip_set` high for exactly one cycle, on the cycle after the edge that first samples `cs_n` high. `trip_reset` stays 0 throughout.
- R5: The same sequence with address 03h produces `trip_reset` high for exactly one cycle, and `trip_set` stays 0.
- R6: An enabled write with `wp_hv` low, or with data other than 00h, or to an address other than 01h or 03h, is an ordinary array write. A later rise of `cs_n` produces no `trip_set` or `trip_reset` pulse.
- R7: Any accepted command other than a write or a write-enable while `wel` is 1 clears `wel`. A write that follows it produces no array write.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values and `cmd_ready` is 0.
- R9: From the accepted calibration write until completion, `cmd_ready` is 0. After the set or reset pulse, a falling `wp_pin` gives `trip_done` high for one cycle, and `cmd_ready` returns to 1 on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Decoded command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | OP_W | Command opcode |
| cmd_addr | input | ADDR_W | Command address |
| cmd_data | input | DATA_W | Command data byte |
| cs_n | input | 1 | Chip-select, active low |
| wp_pin | input | 1 | Write-protect pin logic level |
| wp_hv | input | 1 | Write-protect is at programming voltage |
| wr_valid | output | 1 | Array write pending |
| wr_ready | input | 1 | Array accepts the write |
| wr_addr | output | ADDR_W | Array write address |
| wr_data | output | DATA_W | Array write data |
| wel | output | 1 | Write-enable latch |
| trip_set | output | 1 | Request: program threshold to the present supply |
| trip_reset | output | 1 | Request: reset threshold to its native level |
| trip_done | output | 1 | Calibration completed by write-protect falling |

## Verification
The hardest state to reach is the wait between the calibration write and the rise of chip-select. Several things must coincide there: write-enable accepted, the high-voltage flag held through the write, the exact address and data, and chip-select kept low until after acceptance. The stimulus builds this step by step, with the bench's command task holding `cs_n` low. It then raises chip-select and lowers write-protect on chosen cycles. The same path is also driven with one condition missing at a time, to show that it falls back to a plain array write. Back-pressure is exercised by holding `wr_ready` low while a command waits upstream.

// File: rtl/trip_prog_pkg.sv
package trip_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARMED   = 3'd1,
    ST_LOADED  = 3'd2,
    ST_PENDING = 3'd3,
    ST_DONE    = 3'd4
  } seq_state_t;

  typedef enum logic {
    KIND_SET   = 1'b0,
    KIND_RESET = 1'b1
  } trip_kind_t;
endpackage

// File: rtl/trip_cmd_match.sv
module trip_cmd_match #(
  parameter int OP_W       = 8,
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter logic [OP_W-1:0]   OP_WREN    = 8'h06,
  parameter logic [OP_W-1:0]   OP_WRITE   = 8'h02,
  parameter logic [ADDR_W-1:0] SET_ADDR   = 10'h001,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 10'h003,
  parameter logic [DATA_W-1:0] TRIP_DATA  = 8'h00
) (
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              hv,
  output logic              is_wren,
  output logic              is_write,
  output logic              is_trip,
  output trip_prog_pkg::trip_kind_t kind
);
  import trip_prog_pkg::*;
  logic hit_set, hit_rst;

  always_comb begin
    is_wren  = (op == OP_WREN);
    is_write = (op == OP_WRITE);
    hit_set  = (addr == SET_ADDR);
    hit_rst  = (addr == RESET_ADDR);
    is_trip  = is_write && hv && (data == TRIP_DATA) && (hit_set || hit_rst);
    kind     = hit_rst ? KIND_RESET : KIND_SET;
  end
endmodule

// File: rtl/trip_seq_fsm.sv
module trip_seq_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic is_wren,
  input  logic is_write,
  input  logic is_trip,
  input  trip_prog_pkg::trip_kind_t kind,
  input  logic cs_n,
  input  logic wp_pin,
  output trip_prog_pkg::seq_state_t state,
  output logic wr_fire,
  output logic trip_set,
  output logic trip_reset,
  output logic trip_done
);
  import trip_prog_pkg::*;

  seq_state_t nxt;
  trip_kind_t kind_q;
  logic cs_q, wp_q, cs_rise, wp_fall;

  always_comb begin
    cs_rise = cs_n & ~cs_q;
    wp_fall = ~wp_pin & wp_q;
    wr_fire = acc && is_write && (state == ST_ARMED);
    nxt     = state;
    case (state)
      ST_IDLE:    if (acc && is_wren) nxt = ST_ARMED;
      ST_ARMED:   if (acc) begin
                    if (is_wren)      nxt = ST_ARMED;
                    else if (is_trip) nxt = ST_LOADED;
                    else              nxt = ST_IDLE;
                  end
      ST_LOADED:  if (cs_rise) nxt = ST_PENDING;
      ST_PENDING: if (wp_fall) nxt = ST_DONE;
      ST_DONE:    nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind_q     <= KIND_SET;
      cs_q       <= 1'b1;
      wp_q       <= 1'b1;
      trip_set   <= 1'b0;
      trip_reset <= 1'b0;
    end else begin
      state      <= nxt;
      cs_q       <= cs_n;
      wp_q       <= wp_pin;
      if (state == ST_ARMED && acc && is_trip) kind_q <= kind;
      trip_set   <= (state == ST_LOADED) && cs_rise && (kind_q == KIND_SET);
      trip_reset <= (state == ST_LOADED) && cs_rise && (kind_q == KIND_RESET);
    end
  end

  assign trip_done = (state == ST_DONE);

  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(trip_set && trip_reset));
  assert_set_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_set |=> !trip_set);
  assert_reset_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_reset |=> !trip_reset);
  assert_pulse_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_set || trip_reset) |-> state == ST_PENDING);
  assert_other_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && acc && !is_wren && !is_write) |=> state == ST_IDLE);
  assert_done_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trip_done |=> state == ST_IDLE);
endmodule

// File: rtl/trip_wr_slot.sv
module trip_wr_slot #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= in_addr;
      wr_data  <= in_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/trip_prog_seq.sv
module trip_prog_seq #(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cs_n,
  input  logic              wp_pin,
  input  logic              wp_hv,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wel,
  output logic              trip_set,
  output logic              trip_reset,
  output logic              trip_done
);
  import trip_prog_pkg::*;

  logic is_wren, is_write, is_trip, acc, wr_fire;
  trip_kind_t kind;
  seq_state_t state;

  trip_cmd_match #(.OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .op(cmd_op), .addr(cmd_addr), .data(cmd_data), .hv(wp_hv),
    .is_wren(is_wren), .is_write(is_write), .is_trip(is_trip), .kind(kind)
  );

  assign cmd_ready = ((state == ST_IDLE) || (state == ST_ARMED)) && !wr_valid;
  assign acc       = cmd_valid && cmd_ready;
  assign wel       = (state == ST_ARMED);

  trip_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .acc(acc),
    .is_wren(is_wren), .is_write(is_write), .is_trip(is_trip), .kind(kind),
    .cs_n(cs_n), .wp_pin(wp_pin), .state(state), .wr_fire(wr_fire),
    .trip_set(trip_set), .trip_reset(trip_reset), .trip_done(trip_done)
  );

  trip_wr_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(wr_fire),
    .in_addr(cmd_addr), .in_data(cmd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assert_ready_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !cmd_ready);
  assert_wren_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && is_wren) |=> wel);
  assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && is_write && wel) |=> (!wel && wr_valid));
endmodule

// File: tb/trip_prog_seq_tb.sv
module trip_prog_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = '0;
  logic [9:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic cs_n = 1'b0, wp_pin = 1'b1, wp_hv = 1'b0, wr_ready = 1'b1;
  logic cmd_ready, wr_valid, wel, trip_set, trip_reset, trip_done;
  logic [9:0] wr_addr;
  logic [7:0] wr_data;

  int total = 0, bad = 0;
  int n_set = 0, n_rst = 0, n_done = 0, n_wr = 0;
  logic [17:0] expq[$];

  always #2 clk = ~clk;

  trip_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cs_n(cs_n), .wp_pin(wp_pin), .wp_hv(wp_hv),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wel(wel), .trip_set(trip_set), .trip_reset(trip_reset), .trip_done(trip_done)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (trip_set) n_set++;
    if (trip_reset) n_rst++;
    if (trip_done) n_done++;
    if (wr_valid && wr_ready) begin
      n_wr++;
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R3 actual=unexpected write %h/%h expected=none", wr_addr, wr_data);
      end else begin
        logic [17:0] e;
        e = expq.pop_front();
        if (e != {wr_addr, wr_data}) begin
          bad++;
          $display("FAIL R3 actual=%h expected=%h", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  task automatic send(input logic [7:0] op, input logic [9:0] a, input logic [7:0] d,
                      input bit expect_wr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    if (expect_wr) expq.push_back({a, d});
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cal(input logic [9:0] a, input logic [7:0] d, input logic hv,
                     input bit trip);
    int s0, r0, d0;
    s0 = n_set; r0 = n_rst; d0 = n_done;
    cs_n = 1'b0; wp_hv = hv;
    send(8'h06, 0, 0, 0);
    send(8'h02, a, d, 1);
    wp_hv = 1'b0;
    idle(2);
    cs_n = 1'b1;
    idle(3);
    cs_n = 1'b0;
    if (trip) begin
      check("R9 ready low while pending", cmd_ready, 0);
      wp_pin = 1'b0;
      idle(1);
      check("R9 done pulse", trip_done, 1);
      idle(1);
      check("R9 ready back", cmd_ready, 1);
      check("R9 done count", n_done - d0, 1);
      wp_pin = 1'b1;
      idle(1);
    end
    if (trip && a == 10'h001) begin
      check("R4 set count", n_set - s0, 1);
      check("R4 no reset", n_rst - r0, 0);
    end else if (trip) begin
      check("R5 reset count", n_rst - r0, 1);
      check("R5 no set", n_set - s0, 0);
    end else begin
      check("R6 no set", n_set - s0, 0);
      check("R6 no reset", n_rst - r0, 0);
      check("R6 ready", cmd_ready, 1);
    end
  endtask

  initial begin
    int w0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", cmd_ready, 1);
    check("R1 wel", wel, 0);
    check("R1 wr_valid", wr_valid, 0);
    check("R1 pulses", trip_set | trip_reset | trip_done, 0);

    send(8'h06, 0, 0, 0);
    check("R2 wel set", wel, 1);
    send(8'h02, 10'h055, 8'hA5, 1);
    idle(1);
    check("R3 wel cleared", wel, 0);
    check("R3 one write", n_wr, 1);
    w0 = n_wr;
    send(8'h02, 10'h066, 8'h11, 0);
    idle(3);
    check("R3 write without enable ignored", n_wr - w0, 0);

    cal(10'h001, 8'h00, 1'b1, 1);
    cal(10'h003, 8'h00, 1'b1, 1);
    cal(10'h001, 8'h00, 1'b0, 0);
    cal(10'h003, 8'h5A, 1'b1, 0);
    cal(10'h002, 8'h00, 1'b1, 0);

    send(8'h06, 0, 0, 0);
    send(8'h05, 0, 0, 0);
    check("R7 wel cleared", wel, 0);
    w0 = n_wr;
    send(8'h02, 10'h077, 8'h22, 0);
    idle(3);
    check("R7 following write ignored", n_wr - w0, 0);

    wr_ready = 1'b0;
    send(8'h06, 0, 0, 0);
    send(8'h02, 10'h123, 8'h3C, 1);
    idle(1);
    check("R8 valid held", wr_valid, 1);
    check("R8 ready low", cmd_ready, 0);
    idle(3);
    check("R8 addr stable", wr_addr, 10'h123);
    check("R8 data stable", wr_data, 8'h3C);
    wr_ready = 1'b1;
    idle(3);
    check("R8 drained", wr_valid, 0);
    check("R3 queue empty", expq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule